// File: doc/BRIEF.md
# Three-Phase Bridge Gate Gating and Protection

This block sits between a commutation sequencer and the six gate drivers of a three-phase half-bridge power stage. Each cycle it takes the sequencer's per-phase high-side and low-side switch requests. It combines them with the PWM on-phase, an overcurrent trip, a brake command, an undervoltage trip and a phase-C high-side feedback. From these it produces the final registered gate levels. High-side gates are active low and low-side gates are active high. An active-low fault output reports undervoltage.

Speed PWM and current limiting only chop the low-side switches. The high side keeps its commutation pattern. An overcurrent trip opens a fixed blanking window of a programmable number of cycles. Braking shorts the motor through all low-side switches and suspends current limiting. Undervoltage turns every switch off. A strobe marks the step out of the rotor-align state. After it, the phase-C low-side switch is held off until the phase-C high-side driver reports that it is off. This prevents a shoot-through while that leg changes over.

Top module: `gate_guard`

## Requirements
- R1: Reset is synchronous and active high. While reset is asserted, and until the first update after its release, hs_n_o is 3'b111, ls_o is 3'b000 and fault_n_o is 1.
- R2: Run mode applies when uv_trip is 0, brake_n is 1 and no blanking window is active. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. Outputs update one clock after the inputs are sampled. In run mode, hs_n_o[i] is the inverse of hi_req[i], and ls_o[i] is lo_req[i] AND pwm_on.
- R3: A blanking window opens when oc_trip is 1 at a clock edge with uv_trip at 0, brake_n at 1 and no window open. The window forces ls_o to 3'b000 for exactly OFF_CYCLES consecutive updates, beginning with the update that samples the trip. hs_n_o keeps following R2 during the window.
- R4: An oc_trip that arrives while a window is open does not lengthen the window. If oc_trip is still 1 at the first edge after the window ends, a new window opens.
- R5: Brake applies when brake_n is 0 and uv_trip is 0. It drives hs_n_o to 3'b111 and ls_o to 3'b111, apart from phase-C low-side gating under R7. It overrides PWM and the requests. It ignores oc_trip and cancels any open blanking window.
- R6: When uv_trip is 1, the next update gives hs_n_o 3'b111, ls_o 3'b000 and fault_n_o 0, and cancels any blanking window. In every other cycle fault_n_o is 1.
- R7: A 1 on align_done arms the phase-C interlock. The interlock disarms at the first edge where hc_off_fb is 1 and align_done is 0. In any update where the interlock is armed, or align_done is 1, and hc_off_fb is 0, ls_o[2] is 0.
- R8: When hi_req[i] and lo_req[i] are both 1 in run mode or during a window, both switches of phase i are off. In no update is any phase's high-side gate on together with its low-side gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_req | input | 3 | High-side switch requests per phase (1 = on), bit 0 = A |
| lo_req | input | 3 | Low-side switch requests per phase (1 = on), bit 0 = A |
| pwm_on | input | 1 | PWM on-phase, 1 allows low-side conduction |
| oc_trip | input | 1 | Overcurrent comparator trip, active high |
| brake_n | input | 1 | Brake command, active low |
| uv_trip | input | 1 | Undervoltage trip, active high |
| hc_off_fb | input | 1 | Phase-C high-side driver reports off |
| align_done | input | 1 | One-cycle strobe on leaving the align state |
| hs_n_o | output | 3 | High-side gates, active low |
| ls_o | output | 3 | Low-side gates, active high |
| fault_n_o | output | 1 | Undervoltage fault, active low |

## Verification
The bench builds the block with OFF_CYCLES set to 5. That keeps the blanking window short enough for the random stream to hit its first and last cycles hundreds of times. The same setting reaches the immediate retrigger at the first edge after a window, and trips that land inside an open window. Brake and undervoltage interrupt open windows often, and interlock arming overlaps every mode. A directed sequence pins the window length with a mid-window trip, and another pins the behaviour when both requests of one phase are set.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        GM_RUN     = 2'd0,
        GM_LIMIT   = 2'd1,
        GM_BRAKE   = 2'd2,
        GM_LOCKOUT = 2'd3
    } gate_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    // Priority: lockout over brake over current limit over run.
    function automatic gate_mode_e pick_mode(input logic uv, input logic brake, input logic blank);
        if (uv)         return GM_LOCKOUT;
        else if (brake) return GM_BRAKE;
        else if (blank) return GM_LIMIT;
        else            return GM_RUN;
    endfunction

    function automatic leg_t resolve_leg(input gate_mode_e mode, input logic hi_req,
                                         input logic lo_req, input logic pwm,
                                         input logic lo_inhibit);
        leg_t r;
        r = '0;
        case (mode)
            GM_LOCKOUT: r = '0;
            GM_BRAKE: begin
                r.hi = 1'b0;
                r.lo = ~lo_inhibit;
            end
            GM_LIMIT: begin
                r.hi = hi_req & ~lo_req;
                r.lo = 1'b0;
            end
            default: begin
                r.hi = hi_req & ~lo_req;
                r.lo = lo_req & ~hi_req & pwm & ~lo_inhibit;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gate_guard_offtimer.sv
module gate_guard_offtimer #(
    parameter int OFF_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic trip,
    output logic blank
);
    localparam int CW = (OFF_CYCLES < 2) ? 1 : $clog2(OFF_CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(OFF_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          idle;
    logic          fire;

    assign idle  = (cnt_q == '0);
    assign fire  = enable & trip & idle;
    assign blank = enable & (fire | ~idle);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= RELOAD;
        end else if (!idle) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/gate_guard_xlock.sv
module gate_guard_xlock (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic fb_off,
    output logic inhibit
);
    logic armed_q;

    assign inhibit = (armed_q | arm) & ~fb_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (arm) begin
            armed_q <= 1'b1;
        end else if (fb_off) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/gate_guard_leg.sv
module gate_guard_leg
    import gate_guard_pkg::*;
#(
    parameter bit HAS_XLOCK = 1'b0
) (
    input  gate_mode_e mode,
    input  logic       hi_req,
    input  logic       lo_req,
    input  logic       pwm,
    input  logic       xlock_inhibit,
    output leg_t       drive
);
    logic inhibit;

    generate
        if (HAS_XLOCK) begin : g_locked
            assign inhibit = xlock_inhibit;
        end else begin : g_free
            assign inhibit = 1'b0;
        end
    endgenerate

    assign drive = resolve_leg(mode, hi_req, lo_req, pwm, inhibit);
endmodule

// File: rtl/gate_guard.sv
module gate_guard
    import gate_guard_pkg::*;
#(
    parameter int OFF_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hi_req,
    input  logic [2:0] lo_req,
    input  logic       pwm_on,
    input  logic       oc_trip,
    input  logic       brake_n,
    input  logic       uv_trip,
    input  logic       hc_off_fb,
    input  logic       align_done,
    output logic [2:0] hs_n_o,
    output logic [2:0] ls_o,
    output logic       fault_n_o
);
    logic       blank;
    logic       xinhibit;
    logic       limit_en;
    gate_mode_e mode;
    leg_t       legs [PHASES];
    logic [PHASES-1:0] hi_next;
    logic [PHASES-1:0] lo_next;

    assign limit_en = brake_n & ~uv_trip;

    gate_guard_offtimer #(.OFF_CYCLES(OFF_CYCLES)) u_offtimer (
        .clk    (clk),
        .rst    (rst),
        .enable (limit_en),
        .trip   (oc_trip),
        .blank  (blank)
    );

    gate_guard_xlock u_xlock (
        .clk     (clk),
        .rst     (rst),
        .arm     (align_done),
        .fb_off  (hc_off_fb),
        .inhibit (xinhibit)
    );

    assign mode = pick_mode(uv_trip, ~brake_n, blank);

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_leg
            gate_guard_leg #(.HAS_XLOCK(p == PHASES - 1)) u_leg (
                .mode          (mode),
                .hi_req        (hi_req[p]),
                .lo_req        (lo_req[p]),
                .pwm           (pwm_on),
                .xlock_inhibit (xinhibit),
                .drive         (legs[p])
            );
            assign hi_next[p] = legs[p].hi;
            assign lo_next[p] = legs[p].lo;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_n_o    <= '1;
            ls_o      <= '0;
            fault_n_o <= 1'b1;
        end else begin
            hs_n_o    <= ~hi_next;
            ls_o      <= lo_next;
            fault_n_o <= ~uv_trip;
        end
    end
endmodule

// File: rtl/gate_guard_chk.sv
module gate_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       oc_trip,
    input logic       brake_n,
    input logic       uv_trip,
    input logic       hc_off_fb,
    input logic       align_done,
    input logic [2:0] hs_n_o,
    input logic [2:0] ls_o,
    input logic       fault_n_o
);
    // R8
    no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
        ((~hs_n_o & ls_o) == 3'b000));

    // R6
    uv_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        uv_trip |=> (hs_n_o == 3'b111 && ls_o == 3'b000 && !fault_n_o));

    // R5
    brake_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (!uv_trip && !brake_n) |=> (hs_n_o == 3'b111 && ls_o[1:0] == 2'b11 && fault_n_o));

    // R3
    oc_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (oc_trip && brake_n && !uv_trip) |=> (ls_o == 3'b000));

    // R7
    xlock_chk: assert property (@(posedge clk) disable iff (rst)
        (align_done && !hc_off_fb) |=> !ls_o[2]);
endmodule

bind gate_guard gate_guard_chk u_gate_guard_chk (
    .clk        (clk),
    .rst        (rst),
    .oc_trip    (oc_trip),
    .brake_n    (brake_n),
    .uv_trip    (uv_trip),
    .hc_off_fb  (hc_off_fb),
    .align_done (align_done),
    .hs_n_o     (hs_n_o),
    .ls_o       (ls_o),
    .fault_n_o  (fault_n_o)
);

// File: tb/test_gate_guard.sv
`timescale 1ns/1ps
module test_gate_guard;
    localparam int OFFC = 5;
    localparam real HALF = 4.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hi_req = '0, lo_req = '0;
    logic       pwm_on = 1'b0, oc_trip = 1'b0, brake_n = 1'b1, uv_trip = 1'b0;
    logic       hc_off_fb = 1'b0, align_done = 1'b0;
    logic [2:0] hs_n_o, ls_o;
    logic       fault_n_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    int m_cnt = 0;
    bit m_lock = 0;

    always #(HALF) clk = ~clk;

    gate_guard #(.OFF_CYCLES(OFFC)) i_gate_guard (
        .clk(clk), .rst(rst), .hi_req(hi_req), .lo_req(lo_req), .pwm_on(pwm_on),
        .oc_trip(oc_trip), .brake_n(brake_n), .uv_trip(uv_trip), .hc_off_fb(hc_off_fb),
        .align_done(align_done), .hs_n_o(hs_n_o), .ls_o(ls_o), .fault_n_o(fault_n_o)
    );

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] expect_out(input logic [2:0] h, input logic [2:0] l,
            input logic p, input logic oc, input logic bn, input logic uv,
            input logic ae, input logic fb, output string tag, output bit gated_c);
        logic [2:0] he, le;
        bit trig, blank;
        gated_c = (m_lock || ae) && !fb;
        trig  = !uv && bn && oc && (m_cnt == 0);
        blank = !uv && bn && (trig || m_cnt != 0);
        if (uv) begin
            tag = "R6"; he = 3'b000; le = 3'b000;
            return {~he, le, 1'b0};
        end
        if (!bn) begin
            tag = "R5"; he = 3'b000; le = 3'b111;
            if (gated_c) le[2] = 1'b0;
            return {~he, le, 1'b1};
        end
        he = h & ~l;
        le = l & ~h & {3{p}};
        if (gated_c) le[2] = 1'b0;
        if (blank) begin
            tag = "R3"; le = 3'b000;
        end else if ((h & l) != 0) tag = "R8";
        else tag = "R2";
        return {~he, le, 1'b1};
    endfunction

    task automatic model_update(input logic oc, input logic bn, input logic uv,
                                input logic ae, input logic fb);
        bit trig;
        trig = !uv && bn && oc && (m_cnt == 0);
        if (uv || !bn) m_cnt = 0;
        else if (trig) m_cnt = OFFC - 1;
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        if (ae) m_lock = 1;
        else if (fb) m_lock = 0;
    endtask

    task automatic step(input logic [2:0] h, input logic [2:0] l, input logic p,
                        input logic oc, input logic bn, input logic uv,
                        input logic ae, input logic fb);
        logic [6:0] exp;
        string tag;
        bit gc;
        @(negedge clk);
        hi_req = h; lo_req = l; pwm_on = p; oc_trip = oc; brake_n = bn;
        uv_trip = uv; align_done = ae; hc_off_fb = fb;
        exp = expect_out(h, l, p, oc, bn, uv, ae, fb, tag, gc);
        @(posedge clk);
        #1;
        check(tag, {hs_n_o, ls_o, fault_n_o}, exp);
        if (gc && !uv) check("R7", {6'b0, ls_o[2]}, 7'b0);
        check("R8", {4'b0, ~hs_n_o & ls_o}, 7'b0);
        model_update(oc, bn, uv, ae, fb);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE));
        repeat (3) @(posedge clk);
        #1;
        // R1: all-off during reset
        check("R1", {hs_n_o, ls_o, fault_n_o}, 7'b1110001);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", {hs_n_o, ls_o, fault_n_o}, 7'b1110001);

        // R2: plain commutation patterns
        step(3'b001, 3'b010, 1, 0, 1, 0, 0, 1);
        step(3'b100, 3'b001, 1, 0, 1, 0, 0, 1);
        step(3'b010, 3'b100, 0, 0, 1, 0, 0, 1);

        // R3 / R4: trip, second trip inside the window, then release
        step(3'b001, 3'b010, 1, 1, 1, 0, 0, 1);
        step(3'b001, 3'b010, 1, 0, 1, 0, 0, 1);
        step(3'b001, 3'b010, 1, 1, 1, 0, 0, 1);
        step(3'b001, 3'b010, 1, 0, 1, 0, 0, 1);
        step(3'b001, 3'b010, 1, 0, 1, 0, 0, 1);
        check("R3", {4'b0, ls_o}, 7'b0);
        step(3'b001, 3'b010, 1, 0, 1, 0, 0, 1);
        check("R4", {4'b0, ls_o}, {4'b0, 3'b010});

        // R8: both requests on one phase
        step(3'b001, 3'b001, 1, 0, 1, 0, 0, 1);
        check("R8", {hs_n_o, ls_o, 1'b0}, {3'b111, 3'b000, 1'b0});

        // R7: interlock holds phase-C low side until feedback
        step(3'b010, 3'b100, 1, 0, 1, 0, 1, 0);
        step(3'b010, 3'b100, 1, 0, 1, 0, 0, 0);
        check("R7", {6'b0, ls_o[2]}, 7'b0);
        step(3'b010, 3'b100, 1, 0, 1, 0, 0, 1);
        step(3'b010, 3'b100, 1, 0, 1, 0, 0, 1);
        check("R7", {6'b0, ls_o[2]}, 7'b1);

        // R5: brake cancels an open window; R6 overrides brake
        step(3'b001, 3'b010, 1, 1, 1, 0, 0, 1);
        step(3'b001, 3'b010, 1, 1, 0, 0, 0, 1);
        step(3'b001, 3'b010, 1, 0, 1, 0, 0, 1);
        check("R5", {4'b0, ls_o}, {4'b0, 3'b010});
        step(3'b001, 3'b010, 1, 0, 0, 1, 0, 1);
        check("R6", {6'b0, fault_n_o}, 7'b0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] h, l;
            h = 3'($urandom);
            l = 3'($urandom);
            if ($urandom % 4 != 0) l = l & ~h;
            step(h, l, ($urandom % 3) != 0, ($urandom % 7) == 0,
                 ($urandom % 10) != 0, ($urandom % 25) == 0,
                 ($urandom % 30) == 0, ($urandom % 2) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule